// File: doc/BRIEF.md
# Decimal Accumulator Teaching Processor

This block is a small multicycle processor built around one accumulator. Each instruction is a three-digit decimal word. The hundreds digit selects the operation. The two low digits name one of one hundred mailboxes in an internal memory. Each mailbox holds a value from 0 to 999 in binary. Every instruction passes through a visible chain of registers. The program counter feeds the address register. The addressed word lands in the data register. That word moves into the instruction register, which is then split into an operation digit and a mailbox number. Operand reads and stores use the same address and data registers.

A program is written into the mailboxes through a load port while the core is held in reset. After reset is released, execution starts at mailbox 0. Values enter the accumulator through a valid/ready input port. Values leave as a one-cycle strobe on the output port. The accumulator carries a separate negative flag, which steers the two conditional branches. An opcode that halts the core parks it until the next reset.

Top module: `dec_acc_cpu`

## Requirements
- R1: While `rst_n` is low, and in the cycles after its release before any instruction completes, `halted`, `in_ready` and `out_strobe` are low. Execution starts with the word at mailbox 0.
- R2: When `ld_en` is high while `rst_n` is low, `ld_data` is written into mailbox `ld_addr`. When `rst_n` is high, `ld_en` has no effect on memory.
- R3: An instruction is fetched in three steps: PC to address register; read into data register while PC advances; data register to instruction register. A decode state follows. Branch, no-op, output and halt instructions take 4 cycles. Load, add, subtract and store take 6 cycles. Two back-to-back 902 words strobe 4 cycles apart. A 902 that follows a subtract strobes 10 cycles after the previous 902's strobe.
- R4: 5xx loads mailbox xx into the accumulator. 1xx adds mailbox xx modulo 1000. Both clear the negative flag.
- R5: 2xx subtracts mailbox xx. A result below zero leaves accumulator+1000−operand and sets the negative flag. Otherwise the flag is cleared.
- R6: 3xx writes the accumulator into mailbox xx.
- R7: 6xx always continues execution at mailbox xx.
- R8: 7xx continues at mailbox xx only when the accumulator is 0 and the negative flag is clear.
- R9: 8xx continues at mailbox xx only when the negative flag is clear.
- R10: 901 raises `in_ready` and holds it, stalling, until `in_valid` is seen. It then loads `in_data` into the accumulator and clears the negative flag.
- R11: 902 raises `out_strobe` for exactly one cycle, with `out_data` equal to the accumulator.
- R12: A word whose hundreds digit is 0 halts the core. `halted` then stays high until reset, with no further strobes and `in_ready` low.
- R13: 4xx words, and 9xx words other than 901 and 902, change nothing but the PC. The PC wraps from 99 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; also enables the load port |
| ld_en | input | 1 | Program load write enable |
| ld_addr | input | 7 | Mailbox written by the load port |
| ld_data | input | 10 | Word written by the load port |
| in_valid | input | 1 | Input value offered |
| in_data | input | 10 | Input value |
| in_ready | output | 1 | Core waiting in its input state |
| out_strobe | output | 1 | One-cycle output pulse |
| out_data | output | 10 | Accumulator value on the output pulse |
| halted | output | 1 | Core has executed a halt |

## Verification
The assertions check these properties on every cycle:
- The halt is sticky and quiet.
- The output strobe never lasts two cycles.
- The input state does not drop `in_ready` without a handshake.
- The PC and the accumulator stay inside their decimal ranges.

The arithmetic results, the wrapped subtraction and its flag, and the taken and untaken branches can only be shown by the bench's programs, which compare each strobed value against the expected one. The same holds for store round trips, the cycle spacing of the fetch sequence, PC wrap and the load port being ignored during execution.

// File: rtl/dac_pkg.sv
package dac_pkg;
  typedef enum logic [2:0] {
    ST_FADDR, ST_FREAD, ST_FLATCH, ST_DECODE,
    ST_OPRD, ST_EXEC, ST_INPUT, ST_HALT
  } cpu_state_t;

  typedef enum logic [3:0] {
    OP_HLT, OP_ADD, OP_SUB, OP_STA, OP_LDA,
    OP_BRA, OP_BRZ, OP_BRP, OP_INP, OP_OUT, OP_NOP
  } op_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic core_rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign core_rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/dac_mem.sv
module dac_mem #(
  parameter int WORDS = 100,
  parameter int DW    = 10,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [WORDS];
  logic          in_range;

  assign in_range = {1'b0, waddr} < (AW+1)'(WORDS);

  always_ff @(posedge clk) begin
    if (we && in_range) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dac_decode.sv
module dac_decode
  import dac_pkg::*;
#(
  parameter int WORDS = 100,
  parameter int DW    = 10,
  parameter int AW    = 7
) (
  input  logic [DW-1:0] cir,
  output op_t           op,
  output logic [AW-1:0] opnd
);
  assign opnd = AW'(cir % DW'(WORDS));

  always_comb begin
    case (cir / DW'(WORDS))
      DW'(0): op = OP_HLT;
      DW'(1): op = OP_ADD;
      DW'(2): op = OP_SUB;
      DW'(3): op = OP_STA;
      DW'(5): op = OP_LDA;
      DW'(6): op = OP_BRA;
      DW'(7): op = OP_BRZ;
      DW'(8): op = OP_BRP;
      DW'(9): begin
        if (cir == DW'(9*WORDS + 1))      op = OP_INP;
        else if (cir == DW'(9*WORDS + 2)) op = OP_OUT;
        else                              op = OP_NOP;
      end
      default: op = OP_NOP;
    endcase
  end
endmodule

// File: rtl/dac_alu.sv
module dac_alu #(
  parameter int MAXV = 1000,
  parameter int DW   = 10
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          sub,
  output logic [DW-1:0] res,
  output logic          neg
);
  localparam logic [DW:0] MAXV_E = (DW+1)'(MAXV);

  logic [DW:0] sum_e;
  logic [DW:0] wrap_e;

  assign sum_e  = {1'b0, a} + {1'b0, b};
  assign wrap_e = {1'b0, a} + MAXV_E - {1'b0, b};

  always_comb begin
    if (sub) begin
      neg = a < b;
      res = neg ? DW'(wrap_e) : a - b;
    end else begin
      neg = 1'b0;
      res = (sum_e >= MAXV_E) ? DW'(sum_e - MAXV_E) : DW'(sum_e);
    end
  end
endmodule

// File: rtl/dec_acc_cpu.sv
module dec_acc_cpu
  import dac_pkg::*;
#(
  parameter  int RADIX = 10,
  localparam int WORDS = RADIX * RADIX,
  localparam int MAXV  = WORDS * RADIX,
  localparam int DW    = $clog2(MAXV),
  localparam int AW    = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_strobe,
  output logic [DW-1:0] out_data,
  output logic          halted
);
  logic core_rst_n;

  cpu_state_t    state_q, state_d;
  logic [AW-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [DW-1:0] mdr_q, mdr_d, cir_q, cir_d, acc_q, acc_d, oval_q, oval_d;
  logic          neg_q, neg_d, stb_q, stb_d;
  logic          pc_en, mar_en, mdr_en, cir_en, acc_en, oval_en;

  op_t           op;
  logic [AW-1:0] opnd;
  logic [DW-1:0] mem_rdata, alu_res;
  logic          alu_neg, core_we, load_we;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .core_rst_n(core_rst_n)
  );

  // the load port is only live while the core is held in reset
  assign load_we = ld_en & ~rst_n;

  dac_mem #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .we    (load_we | core_we),
    .waddr (load_we ? ld_addr : mar_q),
    .wdata (load_we ? ld_data : mdr_q),
    .raddr (mar_q),
    .rdata (mem_rdata)
  );

  dac_decode #(.WORDS(WORDS), .DW(DW), .AW(AW)) u_dec (
    .cir(cir_q), .op(op), .opnd(opnd)
  );

  dac_alu #(.MAXV(MAXV), .DW(DW)) u_alu (
    .a(acc_q), .b(mdr_q), .sub(op == OP_SUB), .res(alu_res), .neg(alu_neg)
  );

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;   pc_en   = 1'b0;
    mar_d   = mar_q;  mar_en  = 1'b0;
    mdr_d   = mdr_q;  mdr_en  = 1'b0;
    cir_d   = cir_q;  cir_en  = 1'b0;
    acc_d   = acc_q;  neg_d   = neg_q;  acc_en = 1'b0;
    oval_d  = oval_q; oval_en = 1'b0;
    stb_d   = 1'b0;
    core_we = 1'b0;
    case (state_q)
      ST_FADDR: begin
        mar_d = pc_q; mar_en = 1'b1;
        state_d = ST_FREAD;
      end
      ST_FREAD: begin
        mdr_d = mem_rdata; mdr_en = 1'b1;
        pc_d  = (pc_q == AW'(WORDS-1)) ? '0 : pc_q + 1'b1;
        pc_en = 1'b1;
        state_d = ST_FLATCH;
      end
      ST_FLATCH: begin
        cir_d = mdr_q; cir_en = 1'b1;
        state_d = ST_DECODE;
      end
      ST_DECODE: begin
        state_d = ST_FADDR;
        case (op)
          OP_ADD, OP_SUB, OP_LDA, OP_STA: begin
            mar_d = opnd; mar_en = 1'b1;
            state_d = ST_OPRD;
          end
          OP_BRA: begin pc_d = opnd; pc_en = 1'b1; end
          OP_BRZ: begin pc_d = opnd; pc_en = (acc_q == '0) && !neg_q; end
          OP_BRP: begin pc_d = opnd; pc_en = !neg_q; end
          OP_INP: state_d = ST_INPUT;
          OP_OUT: begin stb_d = 1'b1; oval_d = acc_q; oval_en = 1'b1; end
          OP_HLT: state_d = ST_HALT;
          default: ;
        endcase
      end
      ST_OPRD: begin
        mdr_d  = (op == OP_STA) ? acc_q : mem_rdata;
        mdr_en = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        state_d = ST_FADDR;
        case (op)
          OP_LDA:         begin acc_d = mdr_q;   neg_d = 1'b0;    acc_en = 1'b1; end
          OP_ADD, OP_SUB: begin acc_d = alu_res; neg_d = alu_neg; acc_en = 1'b1; end
          OP_STA:         core_we = 1'b1;
          default: ;
        endcase
      end
      ST_INPUT: begin
        if (in_valid) begin
          acc_d = in_data; neg_d = 1'b0; acc_en = 1'b1;
          state_d = ST_FADDR;
        end
      end
      default: state_d = ST_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      state_q <= ST_FADDR;
      pc_q    <= '0;
      mar_q   <= '0;
      mdr_q   <= '0;
      cir_q   <= '0;
      acc_q   <= '0;
      neg_q   <= 1'b0;
      oval_q  <= '0;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      stb_q   <= stb_d;
      if (pc_en)   pc_q   <= pc_d;
      if (mar_en)  mar_q  <= mar_d;
      if (mdr_en)  mdr_q  <= mdr_d;
      if (cir_en)  cir_q  <= cir_d;
      if (acc_en)  begin acc_q <= acc_d; neg_q <= neg_d; end
      if (oval_en) oval_q <= oval_d;
    end
  end

  assign in_ready   = (state_q == ST_INPUT);
  assign halted     = (state_q == ST_HALT);
  assign out_strobe = stb_q;
  assign out_data   = oval_q;
endmodule

// File: rtl/dac_chk.sv
module dac_chk #(
  parameter int WORDS = 100,
  parameter int MAXV  = 1000,
  parameter int DW    = 10,
  parameter int AW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          halted,
  input logic          out_strobe,
  input logic [DW-1:0] out_data,
  input logic          in_ready,
  input logic          in_valid,
  input logic [AW-1:0] pc,
  input logic [DW-1:0] acc
);
  // R12
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!out_strobe && !in_ready));

  // R11
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |=> !out_strobe);

  // R11
  out_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_strobe |-> (int'(out_data) < MAXV));

  // R10
  input_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  // R13
  pc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pc) < WORDS);

  // R4
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(acc) < MAXV);
endmodule

bind dec_acc_cpu dac_chk #(.WORDS(WORDS), .MAXV(MAXV), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .halted(halted), .out_strobe(out_strobe),
  .out_data(out_data), .in_ready(in_ready), .in_valid(in_valid),
  .pc(pc_q), .acc(acc_q)
);

// File: tb/tb_dec_acc_cpu.sv
`timescale 1ns/1ps
module tb_dec_acc_cpu;
  logic       clk = 1'b0;
  logic       rst_n, ld_en, in_valid;
  logic [6:0] ld_addr;
  logic [9:0] ld_data, in_data;
  logic       in_ready, out_strobe, halted;
  logic [9:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  string tag_q[$];
  int strobe_t[$];
  int e_v;
  string e_t;

  always #2.5 clk = ~clk;

  dec_acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_strobe(out_strobe), .out_data(out_data), .halted(halted)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input int v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_strobe) begin
      strobe_t.push_back(cyc);
      if (exp_q.size() == 0) chk(1'b0, "R11 unexpected strobe", int'(out_data), -1);
      else begin
        e_v = exp_q.pop_front();
        e_t = tag_q.pop_front();
        chk(int'(out_data) == e_v, e_t, int'(out_data), e_v);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      chk(1'b0, "watchdog", cyc, 100000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic put(input int a, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_addr = 7'(a); ld_data = 10'(v);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 100; i++) put(i, 0);
  endtask

  task automatic release_core();
    @(negedge clk);
    ld_en = 1'b0;
    // R1: reset state while held
    chk(!halted && !in_ready && !out_strobe, "R1 reset outputs", {halted, in_ready, out_strobe}, 0);
    rst_n = 1'b1;
    strobe_t.delete();
    @(negedge clk);
    chk(!halted && !in_ready && !out_strobe, "R1 after release", {halted, in_ready, out_strobe}, 0);
  endtask

  task automatic give_input(input int v);
    while (!in_ready) @(negedge clk);
    in_data = 10'(v); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ld_en = 1'b0; ld_addr = '0; ld_data = '0;
    in_valid = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);

    // ---------- program A: arithmetic, store, branches, no-ops ----------
    begin_prog();
    put(0, 550); put(1, 151); put(2, 902); put(3, 252); put(4, 902);
    put(5, 820); put(6, 720); put(7, 355); put(8, 550); put(9, 902);
    put(10, 555); put(11, 902); put(12, 253); put(13, 730); put(14, 0);
    put(30, 902); put(31, 840); put(32, 0);
    put(40, 450); put(41, 905); put(42, 660);
    put(60, 151); put(61, 902); put(62, 0);
    put(50, 700); put(51, 450); put(52, 200); put(53, 950); put(20, 0);
    expect_out(150, "R4 load then add wraps mod 1000");
    expect_out(950, "R5 subtract below zero");
    expect_out(700, "R9 R8 untaken on negative flag");
    expect_out(950, "R6 stored value read back");
    expect_out(0,   "R8 branch on zero taken");
    expect_out(450, "R7 R9 R13 branch always after no-ops");
    release_core();
    while (!halted) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(halted, "R12 halt sticky", halted, 1);
    chk(exp_q.size() == 0, "R12 all outputs seen, none extra", exp_q.size(), 0);
    chk(strobe_t.size() == 6, "R11 strobe count", strobe_t.size(), 6);
    if (strobe_t.size() >= 2)
      chk(strobe_t[1] - strobe_t[0] == 10, "R3 out-sub-out spacing", strobe_t[1] - strobe_t[0], 10);

    // ---------- program B: input, wrap, load port ignored ----------
    begin_prog();
    put(0, 250); put(1, 901); put(2, 710); put(3, 902); put(4, 0);
    put(10, 902); put(11, 901); put(12, 902); put(13, 698);
    put(98, 902); put(99, 902); put(50, 5);
    expect_out(0,   "R10 input clears negative flag");
    expect_out(321, "R10 input value");
    expect_out(321, "R7 branch to 98");
    expect_out(321, "R11 output at 99");
    expect_out(5,   "R2 R13 wrap to 0 and load port ignored");
    release_core();
    ld_en = 1'b1; ld_addr = 7'd3; ld_data = 10'd0;
    repeat (3) @(negedge clk);
    ld_en = 1'b0;
    give_input(0);
    while (!in_ready) @(negedge clk);
    repeat (15) @(negedge clk);
    chk(in_ready, "R10 stall holds in_ready", in_ready, 1);
    chk(strobe_t.size() == 1, "R10 no progress while stalled", strobe_t.size(), 1);
    give_input(321);
    give_input(5);
    while (!halted) @(negedge clk);
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R12 program B outputs complete", exp_q.size(), 0);
    if (strobe_t.size() >= 4)
      chk(strobe_t[3] - strobe_t[2] == 4, "R3 back-to-back output spacing", strobe_t[3] - strobe_t[2], 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule